// File: doc/BRIEF.md
# Asynchronous SRAM Controller

This block sits between a clocked on-chip bus and an external asynchronous static RAM of 64K words by 16 bits. It accepts one single-word command at a time through a valid/ready handshake. Each command is turned into a chip-select, write-strobe and output-enable sequence whose phase lengths are whole clock cycles. A read returns its data with a one-cycle valid pulse. A write reports completion with a one-cycle pulse in the cycle after the write strobe has risen. Two active-low byte-lane strobes, one per byte, restrict a command to the lower byte, the upper byte, both or neither.

The data bus is split into an output path with its own drive enable and an input path. When a command changes direction, the controller inserts turnaround cycles with everything released. This prevents the controller and the memory from driving the bus at the same time. Phase lengths are parameters and must each be at least 1. Integration picks them from the clock period so that the memory's minimum pulse, setup and access times are met.

The controller is a single state machine with these states:
- IDLE: ready, bus released.
- TURN: direction-change gap, everything released.
- WR_SETUP: address, chip select, lanes and data driven, write strobe high.
- WR_PULSE: write strobe low.
- WR_END: write strobe risen, address and data still held, done pulse.
- RD_ACC: chip select and output enable low.
- RD_END: output enable released, valid pulse.

Transitions:
- IDLE goes to TURN on a direction change, otherwise straight to WR_SETUP or RD_ACC.
- TURN goes to the queued phase when its timer expires.
- WR_SETUP goes to WR_PULSE, and WR_PULSE goes to WR_END, each when its timer expires.
- WR_END returns to IDLE.
- RD_ACC goes to RD_END when its timer expires.
- RD_END returns to IDLE.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, req_ready is 1, chip select, write strobe, output enable and both lane strobes are 1 (inactive), mem_dq_oe is 0, and both response pulses are 0.
- R2: A command is taken only in a cycle where req_valid and req_ready are both 1. req_ready drops in the cycle after acceptance and returns to 1 in the cycle after the response pulse.
- R3: A read holds chip select and output enable low and the write strobe high for T_RD cycles. It then raises rsp_rvalid for exactly one cycle, T_RD+1 clock edges after the accepting edge (counting that edge), with the word the memory presented.
- R4: A write holds chip select low for T_SETUP+T_WP+1 cycles and the write strobe low for exactly T_WP consecutive cycles. It keeps mem_dq_oe high with stable data and address across the rising strobe, and pulses rsp_wdone for one cycle T_SETUP+T_WP+1 edges after the accepting edge, in the cycle the strobe has just risen.
- R5: mem_addr never changes between two consecutive cycles in which chip select and write strobe are both low.
- R6: Lane strobe bit 0 (lower byte, data bits 7..0) is low during a cycle exactly when req_be bit 0 was set, and bit 1 likewise for the upper byte, bits 15..8. A write changes only the enabled bytes. A read returns zero in the bits of a disabled lane. A mask of 0 touches nothing and reads zero.
- R7: A read that follows a write takes T_TURN extra cycles, with chip select high and the driver off. Output enable is never low in the cycle after mem_dq_oe was high.
- R8: A write that follows a read takes T_TURN extra cycles. Output enable has been high for at least T_TURN cycles before mem_dq_oe rises.
- R9: mem_dq_oe is never 1 while output enable is low, and the write strobe is never low while output enable is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Command present |
| req_ready | output | 1 | Controller idle, command taken this cycle if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (16) | Word address |
| req_wdata | input | LANES*8 (16) | Write data |
| req_be | input | LANES (2) | Byte-lane mask, bit 0 lower byte |
| rsp_rdata | output | LANES*8 (16) | Read data, valid with rsp_rvalid |
| rsp_rvalid | output | 1 | One-cycle read return pulse |
| rsp_wdone | output | 1 | One-cycle write completion pulse |
| mem_addr | output | ADDR_W (16) | Memory address |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_be_n | output | LANES (2) | Lane strobes, active low, bit 0 lower byte |
| mem_dq_out | output | LANES*8 (16) | Data toward memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | LANES*8 (16) | Data from memory |

## Verification
The bench mixes directed and seeded random traffic, with repeated addresses so that read-after-write data checks the single-lane masking. A design that ignored a lane mask would corrupt the neighbouring byte or return junk from a floating lane. Direction changes are aimed at on purpose. A controller without its turnaround gap shows a response one cycle early, or drives while the model memory still outputs. Each write strobe is watched for its exact low width and for data still driven at its rising edge. The address is watched for any change while both strobes are low, which on a real part would write a second location.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TURN,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_END,
        ST_RD_ACC,
        ST_RD_END
    } ctl_state_e;

    typedef enum logic [1:0] {
        DIR_NONE,
        DIR_RD,
        DIR_WR
    } dir_e;

endpackage

// File: rtl/sram_phase_cnt.sv
module sram_phase_cnt #(
    parameter int unsigned CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_rd_lanes.sv
module sram_rd_lanes #(
    parameter int unsigned LANES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               capture,
    input  logic [LANES-1:0]   lane_en,
    input  logic [LANES*8-1:0] dq_in,
    output logic [LANES*8-1:0] rdata
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rdata[l*8 +: 8] <= '0;
            end else if (capture) begin
                // a disabled lane floats on the bus: return zero instead
                rdata[l*8 +: 8] <= lane_en[l] ? dq_in[l*8 +: 8] : 8'h00;
            end
        end
    end

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W  = 16,
    parameter int unsigned LANES   = 2,
    parameter int unsigned T_SETUP = 1,
    parameter int unsigned T_WP    = 2,
    parameter int unsigned T_RD    = 2,
    parameter int unsigned T_TURN  = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [LANES*8-1:0] req_wdata,
    input  logic [LANES-1:0]   req_be,
    output logic [LANES*8-1:0] rsp_rdata,
    output logic               rsp_rvalid,
    output logic               rsp_wdone,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic               mem_ce_n,
    output logic               mem_we_n,
    output logic               mem_oe_n,
    output logic [LANES-1:0]   mem_be_n,
    output logic [LANES*8-1:0] mem_dq_out,
    output logic               mem_dq_oe,
    input  logic [LANES*8-1:0] mem_dq_in
);

    localparam int unsigned DATA_W = LANES * 8;
    localparam int unsigned T_M1   = (T_SETUP > T_WP) ? T_SETUP : T_WP;
    localparam int unsigned T_M2   = (T_RD > T_TURN) ? T_RD : T_TURN;
    localparam int unsigned T_MAX  = (T_M1 > T_M2) ? T_M1 : T_M2;
    localparam int unsigned CW     = (T_MAX < 2) ? 1 : $clog2(T_MAX);

    localparam logic [CW-1:0] LD_SETUP = CW'(T_SETUP - 1);
    localparam logic [CW-1:0] LD_WP    = CW'(T_WP - 1);
    localparam logic [CW-1:0] LD_RD    = CW'(T_RD - 1);
    localparam logic [CW-1:0] LD_TURN  = CW'(T_TURN - 1);

    ctl_state_e state_q, state_d;
    dir_e       prev_q;

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [LANES-1:0]  be_q;
    logic              wr_q;

    logic          accept;
    logic          turn_need;
    logic          ph_load;
    logic [CW-1:0] ph_val;
    logic          ph_done;
    logic          rd_capture;

    assign accept    = req_valid && (state_q == ST_IDLE);
    assign turn_need = (req_write && prev_q == DIR_RD) ||
                       (!req_write && prev_q == DIR_WR);

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- command capture ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= DIR_NONE;
            addr_q  <= '0;
            wdata_q <= '0;
            be_q    <= '0;
            wr_q    <= 1'b0;
        end else if (accept) begin
            prev_q  <= req_write ? DIR_WR : DIR_RD;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            be_q    <= req_be;
            wr_q    <= req_write;
        end
    end

    // ---------------- next state and phase loads ----------------
    always_comb begin
        state_d = state_q;
        ph_load = 1'b0;
        ph_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    ph_load = 1'b1;
                    if (turn_need) begin
                        state_d = ST_TURN;
                        ph_val  = LD_TURN;
                    end else if (req_write) begin
                        state_d = ST_WR_SETUP;
                        ph_val  = LD_SETUP;
                    end else begin
                        state_d = ST_RD_ACC;
                        ph_val  = LD_RD;
                    end
                end
            end
            ST_TURN: begin
                if (ph_done) begin
                    ph_load = 1'b1;
                    state_d = wr_q ? ST_WR_SETUP : ST_RD_ACC;
                    ph_val  = wr_q ? LD_SETUP : LD_RD;
                end
            end
            ST_WR_SETUP: begin
                if (ph_done) begin
                    ph_load = 1'b1;
                    ph_val  = LD_WP;
                    state_d = ST_WR_PULSE;
                end
            end
            ST_WR_PULSE: begin
                if (ph_done) begin
                    state_d = ST_WR_END;
                end
            end
            ST_WR_END: state_d = ST_IDLE;
            ST_RD_ACC: begin
                if (ph_done) begin
                    state_d = ST_RD_END;
                end
            end
            ST_RD_END: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    sram_phase_cnt #(
        .CW(CW)
    ) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (ph_load),
        .load_val(ph_val),
        .expired (ph_done)
    );

    assign rd_capture = (state_q == ST_RD_ACC) && ph_done;

    sram_rd_lanes #(
        .LANES(LANES)
    ) u_rd_lanes (
        .clk    (clk),
        .rst_n  (rst_n),
        .capture(rd_capture),
        .lane_en(be_q),
        .dq_in  (mem_dq_in),
        .rdata  (rsp_rdata)
    );

    // ---------------- output decode ----------------
    always_comb begin
        req_ready  = 1'b0;
        mem_ce_n   = 1'b1;
        mem_we_n   = 1'b1;
        mem_oe_n   = 1'b1;
        mem_be_n   = '1;
        mem_dq_oe  = 1'b0;
        rsp_rvalid = 1'b0;
        rsp_wdone  = 1'b0;
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_TURN: ;
            ST_WR_SETUP: begin
                mem_ce_n  = 1'b0;
                mem_be_n  = ~be_q;
                mem_dq_oe = 1'b1;
            end
            ST_WR_PULSE: begin
                mem_ce_n  = 1'b0;
                mem_we_n  = 1'b0;
                mem_be_n  = ~be_q;
                mem_dq_oe = 1'b1;
            end
            ST_WR_END: begin
                mem_ce_n  = 1'b0;
                mem_be_n  = ~be_q;
                mem_dq_oe = 1'b1;
                rsp_wdone = 1'b1;
            end
            ST_RD_ACC: begin
                mem_ce_n = 1'b0;
                mem_oe_n = 1'b0;
                mem_be_n = ~be_q;
            end
            ST_RD_END: rsp_rvalid = 1'b1;
            default: ;
        endcase
    end

    assign mem_addr   = addr_q;
    assign mem_dq_out = wdata_q;

    // ---------------- assertions ----------------
    p_ready_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_rd_ctl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_rvalid |-> $past(!mem_ce_n && !mem_oe_n && mem_we_n));

    p_rvalid_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_rvalid |=> !rsp_rvalid);

    p_wdone_after_we_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_wdone |-> (mem_we_n && $past(!mem_we_n)));

    p_dq_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_we_n) && !mem_ce_n) |->
            (mem_dq_oe && $stable(mem_dq_out) && $stable(mem_addr)));

    p_addr_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && !mem_we_n) |=> ($stable(mem_addr) || mem_we_n || mem_ce_n));

    p_rd_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |=> mem_oe_n);

    p_no_contend_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    p_we_oe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);

endmodule

// File: tb/tb_sram_ctrl.sv
module tb_sram_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int T_SETUP = 1;
    localparam int T_WP    = 2;
    localparam int T_RD    = 2;
    localparam int T_TURN  = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic [15:0] rsp_rdata;
    logic        rsp_rvalid;
    logic        rsp_wdone;
    logic [15:0] mem_addr;
    logic        mem_ce_n, mem_we_n, mem_oe_n;
    logic [1:0]  mem_be_n;
    logic [15:0] mem_dq_out;
    logic        mem_dq_oe;
    logic [15:0] mem_dq_in;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_ctrl #(
        .ADDR_W(16), .LANES(2), .T_SETUP(T_SETUP), .T_WP(T_WP),
        .T_RD(T_RD), .T_TURN(T_TURN)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_be(req_be), .rsp_rdata(rsp_rdata), .rsp_rvalid(rsp_rvalid),
        .rsp_wdone(rsp_wdone), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    // ---------------- behavioural memory ----------------
    logic [15:0] mem_m [logic [15:0]];
    logic [15:0] ref_m [logic [15:0]];
    logic        model_drv;

    function automatic logic [15:0] seed_word(input logic [15:0] a);
        return a ^ 16'h5A3C;
    endfunction

    function automatic logic [15:0] model_rd(input logic [15:0] a);
        if (mem_m.exists(a)) return mem_m[a];
        return seed_word(a);
    endfunction

    function automatic logic [15:0] ref_rd(input logic [15:0] a);
        if (ref_m.exists(a)) return ref_m[a];
        return seed_word(a);
    endfunction

    function automatic logic [15:0] lane_mask(input logic [1:0] be);
        return {be[1] ? 8'hFF : 8'h00, be[0] ? 8'hFF : 8'h00};
    endfunction

    always @(mem_addr or mem_ce_n or mem_oe_n or mem_we_n or mem_be_n) begin
        logic [15:0] w;
        model_drv = !mem_ce_n && !mem_oe_n && mem_we_n;
        w = model_rd(mem_addr);
        // a lane not driven floats: model it as junk
        mem_dq_in[7:0]  = (model_drv && !mem_be_n[0]) ? w[7:0]  : 8'hC3;
        mem_dq_in[15:8] = (model_drv && !mem_be_n[1]) ? w[15:8] : 8'h3C;
    end

    always @(posedge mem_we_n) begin
        logic [15:0] w;
        if (rst_n && !mem_ce_n) begin
            if (!mem_dq_oe) begin
                fails++;
                $display("FAIL R4: write strobe rose with driver off, act dq_oe=%0b exp 1", mem_dq_oe);
            end
            w = model_rd(mem_addr);
            if (!mem_be_n[0]) w[7:0]  = mem_dq_out[7:0];
            if (!mem_be_n[1]) w[15:8] = mem_dq_out[15:8];
            mem_m[mem_addr] = w;
        end
    end

    // ---------------- protocol monitor ----------------
    logic [1:0]  cur_be = '0;
    logic        prev_both = 1'b0;
    logic        prev_dq_oe = 1'b0;
    logic [15:0] prev_addr = '0;
    int          we_run = 0;
    int          oe_high_run = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_both && !mem_ce_n && !mem_we_n && mem_addr != prev_addr) begin
                fails++;
                $display("FAIL R5: address moved under write, act %h exp %h", mem_addr, prev_addr);
            end
            if (mem_dq_oe && model_drv) begin
                fails++;
                $display("FAIL R9: bus contention, act dq_oe=1 mem_drive=1 exp not both");
            end
            if (!mem_ce_n && mem_be_n != ~cur_be) begin
                fails++;
                $display("FAIL R6: lane strobes act %b exp %b", mem_be_n, ~cur_be);
            end
            if (!mem_we_n) we_run++;
            else begin
                if (we_run != 0 && we_run != T_WP) begin
                    fails++;
                    $display("FAIL R4: write pulse width act %0d exp %0d", we_run, T_WP);
                end
                we_run = 0;
            end
            if (mem_dq_oe && !prev_dq_oe && oe_high_run < T_TURN) begin
                fails++;
                $display("FAIL R8: output enable high run before drive act %0d exp >= %0d", oe_high_run, T_TURN);
            end
            oe_high_run = mem_oe_n ? oe_high_run + 1 : 0;
            prev_both  = !mem_ce_n && !mem_we_n;
            prev_addr  = mem_addr;
            prev_dq_oe = mem_dq_oe;
        end
    end

    // ---------------- checking helpers ----------------
    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: act %h exp %h", tag, act, exp);
        end
    endtask

    int prev_dir = 0; // 0 none, 1 read, 2 write

    task automatic run_op(input bit wr, input logic [15:0] a, input logic [15:0] d, input logic [1:0] be);
        int  n;
        int  exp_lat;
        bit  turn;
        logic [15:0] exp_d;
        turn    = (wr && prev_dir == 1) || (!wr && prev_dir == 2);
        exp_lat = (wr ? (T_SETUP + T_WP + 1) : (T_RD + 1)) + (turn ? T_TURN : 0);
        n = 0;
        while (!req_ready && n < 50) begin @(negedge clk); n++; end
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
        cur_be = be;
        @(negedge clk);
        req_valid = 1'b0;
        req_wdata = ~d;
        check(!req_ready, "R2 busy", {31'd0, req_ready}, 32'd0);
        n = 1;
        while (!(wr ? rsp_wdone : rsp_rvalid) && n < 60) begin @(negedge clk); n++; end
        if (turn)
            check(n == exp_lat, wr ? "R8 latency" : "R7 latency", n, exp_lat);
        else
            check(n == exp_lat, wr ? "R4 latency" : "R3 latency", n, exp_lat);
        if (!wr) begin
            exp_d = ref_rd(a) & lane_mask(be);
            check(rsp_rdata == exp_d, "R3/R6 read data", {16'd0, rsp_rdata}, {16'd0, exp_d});
        end else begin
            ref_m[a] = (ref_rd(a) & ~lane_mask(be)) | (d & lane_mask(be));
        end
        @(negedge clk);
        check(!(rsp_wdone || rsp_rvalid), "R3/R4 one-cycle pulse", {31'd0, rsp_wdone | rsp_rvalid}, 32'd0);
        check(req_ready, "R2 ready back", {31'd0, req_ready}, 32'd1);
        prev_dir = wr ? 2 : 1;
    endtask

    task automatic check_idle_pins(input string tag);
        check(req_ready && mem_ce_n && mem_we_n && mem_oe_n && mem_be_n == 2'b11 &&
              !mem_dq_oe && !rsp_rvalid && !rsp_wdone, tag,
              {24'd0, req_ready, mem_ce_n, mem_we_n, mem_oe_n, mem_be_n, mem_dq_oe, rsp_rvalid | rsp_wdone},
              {24'd0, 8'b1111_1100});
    endtask

    function automatic logic [15:0] pool(input int i);
        case (i)
            0: return 16'h0000;
            1: return 16'hFFFF;
            default: return 16'(i * 16'h2493) ^ 16'h8001;
        endcase
    endfunction

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: act %0d cycles exp < 150000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        void'($urandom(32'h00C0FFEE));
        repeat (3) @(negedge clk);
        check_idle_pins("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle_pins("R1 after reset");

        // directed corners
        run_op(1'b1, 16'h0000, 16'hA1B2, 2'b11);
        run_op(1'b1, 16'hFFFF, 16'h1357, 2'b11);
        run_op(1'b0, 16'h0000, 16'h0000, 2'b11);   // R7 read after write
        run_op(1'b0, 16'hFFFF, 16'h0000, 2'b11);   // R3 back-to-back read
        run_op(1'b1, 16'h0000, 16'h77CC, 2'b01);   // R8 write after read, lower only
        run_op(1'b1, 16'hFFFF, 16'hEE55, 2'b10);   // R6 upper only
        run_op(1'b1, 16'h0000, 16'h9999, 2'b00);   // R6 empty mask
        run_op(1'b0, 16'h0000, 16'h0000, 2'b11);
        run_op(1'b0, 16'hFFFF, 16'h0000, 2'b01);   // R6 disabled upper reads zero
        run_op(1'b0, 16'hFFFF, 16'h0000, 2'b10);
        run_op(1'b0, 16'h1234, 16'h0000, 2'b00);

        // seeded random mix
        for (int k = 0; k < 300; k++) begin
            run_op(1'($urandom % 2), pool(int'($urandom % 8)), 16'($urandom), 2'($urandom % 4));
        end

        // monitor categories, each counted once
        check(1'b1, "R5 monitor", 0, 0);
        check(1'b1, "R9 monitor", 0, 0);
        check(1'b1, "R6 strobe monitor", 0, 0);
        check(1'b1, "R4 pulse monitor", 0, 0);

        repeat (2) @(negedge clk);
        check_idle_pins("R1 idle at end");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule